// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets an external controller read and write a small bank of configuration registers over four wires. The wires are a frame enable, a serial clock, a serial data input and a serial data output that can be released. The frame enable also serves as the device select, so several slaves can share the clock and data lines, and each one answers only while its own enable is high. The serial pins are asynchronous to the chip clock. They pass through a synchroniser, and the block acts on the detected edges of the serial clock.

A frame is sixteen serial clocks long. The first bit is the direction, then a seven-bit register number, then an eight-bit data field. Every field travels least significant bit first. A write commits when the last data bit is taken in. On a read, the slave drives the output only while it returns the eight data bits. The register contents are also presented in parallel to the rest of the chip.

Top module: `ser_reg_slave`

## Requirements
- R1: After reset, register i (i = 0..7) holds (37*i + 3) mod 256, `ser_oe` is low and `cfg_q[8*i+7:8*i]` shows register i.
- R2: Bits on `ser_in` are taken at rising edges of `ser_clk` while `frame_en` is high. Bit 0 of a frame selects the direction (1 = read, 0 = write). Bits 1..7 give the address, least significant bit first. Bits 8..15 give the data, least significant bit first.
- R3: A write frame updates its target register only after the sixteenth rising edge. No register changes earlier in the frame.
- R4: On a read, the slave drives data bit 0 after the falling edge that follows the eighth rising edge. It moves to the next bit, least significant first, after each later falling edge, so the controller can sample each bit at the following rising edge.
- R5: `ser_oe` is high only while read data is being shifted out. It drops after the falling edge that follows the sixteenth rising edge, and `ser_out` is released whenever `ser_oe` is low.
- R6: Lowering `frame_en` before the sixteenth rising edge abandons the frame. Nothing is written and `ser_oe` goes low.
- R7: Only addresses 0..7 are implemented. Writes to any other address change no register, and reads from them return 0.
- R8: While `frame_en` is low, activity on `ser_clk` and `ser_in` has no effect.
- R9: Rising edges after the sixteenth within one enable period are ignored.
- R10: Every serial edge is handled correctly when each half period of `ser_clk` spans at least five chip clock cycles. This covers a 20 MHz serial clock against a 200 MHz chip clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | chip clock |
| rst_n | input | 1 | asynchronous reset, active low |
| frame_en | input | 1 | frame enable and device select, active high |
| ser_clk | input | 1 | serial clock from the controller, idle low |
| ser_in | input | 1 | serial data into the slave |
| ser_out | output | 1 | serial read data, released when not driving |
| ser_oe | output | 1 | high while `ser_out` is driven |
| cfg_q | output | 64 | parallel view of the eight registers |

## Verification
Single-bit data values such as 0x01 and 0x80, written to neighbouring addresses and read back, separate least-significant-first ordering from a reversed shift. Write-then-read of mixed patterns shows that data lands in the selected register only. Frames cut short at fifteen bits or in the middle of a read, clocks given while the enable is low, and frames with extra clocks distinguish a slave that commits or drives at the correct edge from one that counts edges loosely. Reads and writes at addresses 8 and 64 show that unimplemented locations change nothing and read as zero. A cycle-level model runs alongside and flags any difference in output-enable timing, driven bit or register contents.

// File: rtl/sra_pkg.sv
`timescale 1ns/1ps
package sra_pkg;
    // Reset value of register idx, before truncation to the data width.
    function automatic logic [31:0] reg_default(input int idx);
        return 32'(37 * idx + 3);
    endfunction
endpackage

// File: rtl/sra_sync.sv
`timescale 1ns/1ps
module sra_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg_q [STAGES];
    logic [WIDTH-1:0] stg_d [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                assign stg_d[s] = d;
            end else begin : g_next
                assign stg_d[s] = stg_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= '0;
                else        stg_q[s] <= stg_d[s];
            end
        end
    endgenerate

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/sra_frame.sv
`timescale 1ns/1ps
module sra_frame #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_s,
    input  logic              sclk_s,
    input  logic              din_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              dout,
    output logic              oe
);
    localparam int FRAME_LEN = 1 + ADDR_W + DATA_W;
    localparam int CNT_W     = $clog2(FRAME_LEN + 1);
    localparam logic [CNT_W-1:0] C_ADDR_END = CNT_W'(1 + ADDR_W);
    localparam logic [CNT_W-1:0] C_LAST     = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] C_FULL     = CNT_W'(FRAME_LEN);

    typedef struct packed {
        logic              sclk_prev;
        logic [CNT_W-1:0]  cnt;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [DATA_W-1:0] shf;
        logic              dout;
        logic              oe;
    } frame_st_t;

    frame_st_t st_q, st_d;
    logic rise, fall;

    always_comb begin
        st_d    = st_q;
        wr_en   = 1'b0;
        wr_data = {din_s, st_q.data[DATA_W-1:1]};
        rise    = sclk_s & ~st_q.sclk_prev;
        fall    = ~sclk_s & st_q.sclk_prev;
        st_d.sclk_prev = sclk_s;
        if (!en_s) begin
            st_d.cnt = '0;
            st_d.oe  = 1'b0;
        end else if (rise && st_q.cnt < C_FULL) begin
            if (st_q.cnt == '0)
                st_d.rd = din_s;
            else if (st_q.cnt < C_ADDR_END)
                st_d.addr = {din_s, st_q.addr[ADDR_W-1:1]};
            else
                st_d.data = {din_s, st_q.data[DATA_W-1:1]};
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == C_LAST && !st_q.rd)
                wr_en = 1'b1;
        end else if (fall && st_q.rd) begin
            if (st_q.cnt == C_ADDR_END) begin
                st_d.oe   = 1'b1;
                st_d.dout = rd_data[0];
                st_d.shf  = rd_data >> 1;
            end else if (st_q.cnt > C_ADDR_END && st_q.cnt < C_FULL && st_q.oe) begin
                st_d.dout = st_q.shf[0];
                st_d.shf  = st_q.shf >> 1;
            end else if (st_q.cnt == C_FULL) begin
                st_d.oe = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_addr = st_q.addr;
    assign wr_addr = st_q.addr;
    assign dout    = st_q.dout;
    assign oe      = st_q.oe;

    // R6
    abort_drops_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> !st_q.oe);
    // R4
    oe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.oe) |-> st_q.cnt == C_ADDR_END);
    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= C_FULL);
    // R5
    oe_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.oe |-> st_q.rd);
    // R8
    idle_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> st_q.cnt == '0);
endmodule

// File: rtl/sra_regfile.sv
`timescale 1ns/1ps
module sra_regfile
    import sra_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int ADDR_W   = 7,
    parameter int DATA_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          rd_data,
    output logic [NUM_REGS*DATA_W-1:0] cfg_q
);
    logic [DATA_W-1:0] reg_q [NUM_REGS];
    logic [DATA_W-1:0] reg_d [NUM_REGS];

    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
            always_comb begin
                reg_d[i] = reg_q[i];
                if (wr_en && wr_addr == ADDR_W'(i))
                    reg_d[i] = wr_data;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) reg_q[i] <= DATA_W'(reg_default(i));
                else        reg_q[i] <= reg_d[i];
            end
            assign cfg_q[i*DATA_W +: DATA_W] = reg_q[i];

            // R3
            change_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (reg_q[i] != $past(reg_q[i])) |-> $past(wr_en));
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_addr == ADDR_W'(i)) rd_data = reg_q[i];
    end

    // R7
    unimpl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= ADDR_W'(NUM_REGS)) |=> $stable(cfg_q));
endmodule

// File: rtl/ser_reg_slave.sv
`timescale 1ns/1ps
module ser_reg_slave #(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int NUM_REGS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       frame_en,
    input  logic                       ser_clk,
    input  logic                       ser_in,
    output logic                       ser_out,
    output logic                       ser_oe,
    output logic [NUM_REGS*DATA_W-1:0] cfg_q
);
    logic [2:0]        pins_s;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [DATA_W-1:0] rd_data, wr_data;
    logic              wr_en, dout, oe;

    sra_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({frame_en, ser_clk, ser_in}),
        .q     (pins_s)
    );

    sra_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_s    (pins_s[2]),
        .sclk_s  (pins_s[1]),
        .din_s   (pins_s[0]),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .dout    (dout),
        .oe      (oe)
    );

    sra_regfile #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .cfg_q   (cfg_q)
    );

    assign ser_oe  = oe;
    assign ser_out = oe ? dout : 1'bz;
endmodule

// File: tb/ser_reg_slave_bench.sv
`timescale 1ns/1ps
module ser_reg_slave_bench;
    localparam int HALF = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_en = 1'b0, ser_clk = 1'b0, ser_in = 1'b0;
    wire  ser_out;
    logic ser_oe;
    logic [63:0] cfg_q;

    int total = 0, bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ser_reg_slave u_ser_reg_slave (
        .clk(clk), .rst_n(rst_n), .frame_en(frame_en), .ser_clk(ser_clk),
        .ser_in(ser_in), .ser_out(ser_out), .ser_oe(ser_oe), .cfg_q(cfg_q)
    );

    // Behavioural reference, following the requirements
    int m_regs [8];
    int m_cnt, m_addr, m_data, m_rd, m_oe, m_sdo;
    bit m_en1, m_en2, m_ck1, m_ck2, m_ck3, m_d1, m_d2;

    function automatic int dflt(input int i);
        return (37 * i + 3) % 256;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_regs[i]) m_regs[i] = dflt(i);
            m_cnt = 0; m_addr = 0; m_data = 0; m_rd = 0; m_oe = 0; m_sdo = 0;
            m_en1 = 0; m_en2 = 0; m_ck1 = 0; m_ck2 = 0; m_ck3 = 0; m_d1 = 0; m_d2 = 0;
        end else begin
            bit rise, fall;
            rise = m_ck2 && !m_ck3;
            fall = !m_ck2 && m_ck3;
            if (!m_en2) begin
                m_cnt = 0; m_oe = 0;
            end else if (rise && m_cnt < 16) begin
                if (m_cnt == 0) begin m_rd = int'(m_d2); m_addr = 0; m_data = 0; end
                else if (m_cnt < 8) m_addr = m_addr | (int'(m_d2) << (m_cnt - 1));
                else m_data = m_data | (int'(m_d2) << (m_cnt - 8));
                m_cnt++;
                if (m_cnt == 16 && m_rd == 0 && m_addr < 8) m_regs[m_addr] = m_data;
            end else if (fall && m_rd == 1) begin
                if (m_cnt >= 8 && m_cnt < 16) begin
                    m_oe = 1;
                    m_sdo = ((m_addr < 8 ? m_regs[m_addr] : 0) >> (m_cnt - 8)) & 1;
                end else if (m_cnt == 16) m_oe = 0;
            end
            m_ck3 = m_ck2; m_ck2 = m_ck1; m_ck1 = ser_clk;
            m_en2 = m_en1; m_en1 = frame_en;
            m_d2 = m_d1;   m_d1 = ser_in;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R5 oe timing", int'(ser_oe), m_oe);
            if (m_oe == 1 && ser_oe) chk("R4 driven bit", int'(ser_out), m_sdo);
            for (int i = 0; i < 8; i++)
                chk("R3 register contents", int'(cfg_q[8*i +: 8]), m_regs[i]);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input int rd, input int addr, input int data,
                        input int nrise, output int got);
        got = 0;
        @(negedge clk);
        frame_en = 1'b1;
        for (int i = 0; i < nrise; i++) begin
            int b;
            b = (i == 0) ? rd : (i < 8) ? ((addr >> (i - 1)) & 1)
              : (i < 16) ? ((data >> (i - 8)) & 1) : 0;
            ser_in = b[0];
            idle(HALF);
            if (i >= 8 && i < 16) got = got | (int'(ser_out) << (i - 8));
            ser_clk = 1'b1;
            idle(HALF);
            ser_clk = 1'b0;
        end
        idle(HALF);
        frame_en = 1'b0;
        ser_in = 1'b0;
        idle(6);
    endtask

    task automatic done_run;
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        done_run();
    end

    initial begin
        int got;
        idle(4);
        // R1 reset state
        for (int i = 0; i < 8; i++) chk("R1 reset value", int'(cfg_q[8*i +: 8]), dflt(i));
        chk("R1 oe low", int'(ser_oe), 0);
        rst_n = 1'b1;
        idle(4);
        // R1 R4 R10 read defaults over the serial link
        for (int i = 0; i < 8; i++) begin
            xfer(1, i, 0, 16, got);
            chk("R4 read default", got, dflt(i));
        end
        // R2 R3 write then read back
        xfer(0, 3, 8'hC5, 16, got);
        chk("R3 cfg after write", int'(cfg_q[31:24]), 8'hC5);
        xfer(1, 3, 0, 16, got);
        chk("R2 readback", got, 8'hC5);
        // R2 bit ordering with single-bit values
        xfer(0, 5, 8'h01, 16, got);
        xfer(0, 6, 8'h80, 16, got);
        xfer(1, 5, 0, 16, got);
        chk("R2 lsb first low", got, 8'h01);
        xfer(1, 6, 0, 16, got);
        chk("R2 lsb first high", got, 8'h80);
        // R6 abandon at 15 rising edges
        xfer(0, 2, 8'h3C, 15, got);
        chk("R6 no write on short frame", int'(cfg_q[23:16]), dflt(2));
        chk("R6 oe low", int'(ser_oe), 0);
        // R6 abandon in the middle of a read
        xfer(1, 1, 0, 11, got);
        chk("R6 oe low after abort", int'(ser_oe), 0);
        // R7 unimplemented addresses
        xfer(0, 8'h40, 8'hFF, 16, got);
        xfer(0, 8, 8'hAA, 16, got);
        for (int i = 0; i < 8; i++) begin
            xfer(1, i, 0, 16, got);
            chk("R7 others unchanged", got, m_regs[i]);
        end
        xfer(1, 8'h40, 0, 16, got);
        chk("R7 read zero", got, 0);
        xfer(1, 8, 0, 16, got);
        chk("R7 read zero 8", got, 0);
        // R8 activity while the enable is low
        for (int i = 0; i < 16; i++) begin
            ser_in = i[0]; idle(HALF); ser_clk = 1'b1; idle(HALF); ser_clk = 1'b0;
        end
        idle(6);
        chk("R8 reg0 kept", int'(cfg_q[7:0]), m_regs[0]);
        chk("R8 oe low", int'(ser_oe), 0);
        // R9 extra rising edges
        xfer(0, 7, 8'h96, 20, got);
        chk("R9 write with extra clocks", int'(cfg_q[63:56]), 8'h96);
        xfer(1, 7, 0, 20, got);
        chk("R9 read with extra clocks", got, 8'h96);
        chk("R9 oe low after", int'(ser_oe), 0);
        idle(10);
        done_run();
    end
endmodule